// File: doc/BRIEF.md
# Cell-Bypass Fault Reconfiguration Controller

This block sits between the fault protection of a three-phase cascaded H-bridge inverter and its modulator. Each phase has two cells in series (row 0 and row 1). The block latches per-cell fault flags and turns them into per-cell bypass commands. It can also bypass the healthy remainder of a row that already holds two faulty cells, since that last cell cannot add steady-state voltage. From the bypass pattern it derives two limits:

- the largest output level each phase may still use, which goes to the sequence selector;
- the maximum modulation index, in quarters of the healthy full scale.

The block also limits the incoming reference phasor to that maximum index. A reference that is too long is scaled down with its direction kept. Bypass commands and limits change only on the period-start strobe, so a modulation period is never reconfigured midway. The clamped reference comes out a fixed number of cycles after that strobe.

Top module: `cell_bypass_ctrl`

## Requirements
- R1: Cell faults are numbered so that bit i belongs to phase i/2 (0=U, 1=V, 2=W) and row i%2. A high `fault_i` bit sets the matching latched flag at the clock edge. The flag stays set until `fault_clr` is sampled high. A fault present at the same edge as the clear stays latched.
- R2: `bypass_o` changes only at an edge where `period_start` is high. At that edge it takes the faults latched before that edge. A fault that first appears at the strobe edge waits for the next strobe.
- R3: `lvl_o[2p+1:2p]` gives phase p its largest allowed level magnitude: 2 minus the number of bypassed cells in that phase. The phase then uses levels from -lvl to +lvl.
- R4: `mi_o` is the maximum modulation index in quarters, set from the bypass pattern:
  - no bypass: 4;
  - exactly one bypassed cell: 3;
  - any one of the following: 2
    - both cells of one phase and nothing else;
    - one cell in each of two phases;
    - one cell in each of all three phases;
  - one fully bypassed phase plus any other bypass: 1;
  - two or more fully bypassed phases: 0.
- R5: With `row_fill_en` high, a row (bits r, r+2, r+4) holding two or more latched faults is bypassed completely at the strobe. With `row_fill_en` low, only faulty cells are bypassed.
- R6: The reference limit is L = FULL_SCALE·mi/4, where mi is the new `mi_o`. If a²+b² ≤ L² at the strobe, the reference passes through unchanged and `clamp_o` is 0.
- R7: Otherwise both components are scaled by s/2^FRAC_W and `clamp_o` is 1. Here s is the largest integer below 2^FRAC_W with s²(a²+b²) ≤ L²·2^(2·FRAC_W). Each component's magnitude is truncated and its sign kept.
- R8: The clamped reference and a one-cycle `ref_vld_o` pulse appear at the FRAC_W-th edge after the strobe edge. A new strobe before then restarts the computation.
- R9: With every cell bypassed, the limit is zero and any nonzero reference comes out as (0,0) with `clamp_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 6 | Per-cell fault flags, bit = 2·phase + row |
| fault_clr | input | 1 | Clears latched faults |
| period_start | input | 1 | Modulation-period boundary strobe |
| row_fill_en | input | 1 | Enables whole-row bypass promotion |
| ref_a_i | input | REF_W | Reference real component, signed |
| ref_b_i | input | REF_W | Reference imaginary component, signed |
| bypass_o | output | 6 | Per-cell bypass commands |
| lvl_o | output | 6 | Per-phase level magnitude limit, 2 bits per phase |
| mi_o | output | 3 | Maximum modulation index in quarters |
| ref_a_o | output | REF_W | Clamped real component |
| ref_b_o | output | REF_W | Clamped imaginary component |
| ref_vld_o | output | 1 | One-cycle pulse when the clamped reference updates |
| clamp_o | output | 1 | Last reference was scaled down |

## Verification
The result timing differs by output:
- Fault flags latch one edge after the stimulus.
- `bypass_o`, `lvl_o` and `mi_o` move at the strobe edge itself.
- The clamped reference and `ref_vld_o` land exactly FRAC_W edges after the strobe edge.

Every bench task drives inputs on the falling edge. It reads the configuration at the falling edge just after the strobe. It then confirms that `ref_vld_o` is still low one edge before the clamped result is due, and checks the result at the falling edge after its due edge. The expected scale factor comes from a descending search in the bench, which is independent of the bit-serial search in the block.

// File: rtl/cell_bypass_ctrl.sv
module cell_bypass_ctrl #(
  parameter int REF_W      = 16,
  parameter int FULL_SCALE = 16384,
  parameter int FRAC_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [5:0]              fault_i,
  input  logic                    fault_clr,
  input  logic                    period_start,
  input  logic                    row_fill_en,
  input  logic signed [REF_W-1:0] ref_a_i,
  input  logic signed [REF_W-1:0] ref_b_i,
  output logic [5:0]              bypass_o,
  output logic [5:0]              lvl_o,
  output logic [2:0]              mi_o,
  output logic signed [REF_W-1:0] ref_a_o,
  output logic signed [REF_W-1:0] ref_b_o,
  output logic                    ref_vld_o,
  output logic                    clamp_o
);
  localparam int MW = 2*REF_W + 1;
  localparam int PW = MW + 2*FRAC_W;
  localparam int BW = $clog2(FRAC_W);

  function automatic logic [2:0] index_of(input logic [5:0] b);
    logic [1:0] c, n1, n2;
    n1 = '0;
    n2 = '0;
    for (int p = 0; p < 3; p++) begin
      c = 2'(b[2*p]) + 2'(b[2*p+1]);
      if (c == 2'd2) n2 = n2 + 2'd1;
      else if (c == 2'd1) n1 = n1 + 2'd1;
    end
    if (n2 >= 2'd2)      return 3'd0;
    else if (n2 == 2'd1) return (n1 == 2'd0) ? 3'd2 : 3'd1;
    else if (n1 >= 2'd2) return 3'd2;
    else if (n1 == 2'd1) return 3'd3;
    else                 return 3'd4;
  endfunction

  function automatic logic [REF_W-1:0] lim_of(input logic [2:0] m);
    return REF_W'((FULL_SCALE * int'(m)) / 4);
  endfunction

  logic [5:0]              fault_q, bypass_q, byp_nxt;
  logic [1:0]              row_full;
  logic                    busy_q, over_q;
  logic [BW-1:0]           bit_q;
  logic [FRAC_W-1:0]       s_q, trial, s_nxt;
  logic signed [REF_W-1:0] a_q, b_q;
  logic [MW-1:0]           mag2_q, mag2_in;
  logic [PW-1:0]           tgt_q, lsq_in, tsq;
  logic [REF_W-1:0]        lim_in;

  for (genvar r = 0; r < 2; r++) begin : g_row
    assign row_full[r] = row_fill_en &&
      ((2'(fault_q[r]) + 2'(fault_q[r+2]) + 2'(fault_q[r+4])) >= 2'd2);
    assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && row_fill_en &&
       ((fault_q[r] & fault_q[r+2]) | (fault_q[r] & fault_q[r+4]) | (fault_q[r+2] & fault_q[r+4])))
      |=> (bypass_o[r] && bypass_o[r+2] && bypass_o[r+4]));
  end

  assign byp_nxt = fault_q | {3{row_full}};

  for (genvar p = 0; p < 3; p++) begin : g_ph
    assign lvl_o[2*p +: 2] = 2'd2 - (2'(bypass_q[2*p]) + 2'(bypass_q[2*p+1]));
  end

  assign bypass_o = bypass_q;
  assign mi_o     = index_of(bypass_q);
  assign lim_in   = lim_of(index_of(byp_nxt));

  logic signed [2*REF_W-1:0] ea, eb, pa, pb;
  assign ea      = (2*REF_W)'(ref_a_i);
  assign eb      = (2*REF_W)'(ref_b_i);
  assign pa      = ea * ea;
  assign pb      = eb * eb;
  assign mag2_in = MW'($unsigned(pa)) + MW'($unsigned(pb));
  assign lsq_in  = PW'(lim_in) * PW'(lim_in);

  assign trial = s_q | (FRAC_W'(1) << bit_q);
  assign tsq   = PW'(trial) * PW'(trial) * PW'(mag2_q);
  assign s_nxt = (tsq <= tgt_q) ? trial : s_q;

  logic [REF_W-1:0]        abs_a, abs_b;
  logic [REF_W+FRAC_W-1:0] pra, prb;
  logic [REF_W-1:0]        mga, mgb;
  logic signed [REF_W-1:0] sca, scb;
  assign abs_a = a_q[REF_W-1] ? REF_W'(-a_q) : REF_W'(a_q);
  assign abs_b = b_q[REF_W-1] ? REF_W'(-b_q) : REF_W'(b_q);
  assign pra   = (REF_W+FRAC_W)'(abs_a) * (REF_W+FRAC_W)'(s_nxt);
  assign prb   = (REF_W+FRAC_W)'(abs_b) * (REF_W+FRAC_W)'(s_nxt);
  assign mga   = pra[FRAC_W +: REF_W];
  assign mgb   = prb[FRAC_W +: REF_W];
  assign sca   = a_q[REF_W-1] ? -$signed(mga) : $signed(mga);
  assign scb   = b_q[REF_W-1] ? -$signed(mgb) : $signed(mgb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q   <= '0;
      bypass_q  <= '0;
      busy_q    <= 1'b0;
      over_q    <= 1'b0;
      bit_q     <= '0;
      s_q       <= '0;
      a_q       <= '0;
      b_q       <= '0;
      mag2_q    <= '0;
      tgt_q     <= '0;
      ref_a_o   <= '0;
      ref_b_o   <= '0;
      ref_vld_o <= 1'b0;
      clamp_o   <= 1'b0;
    end else begin
      fault_q   <= fault_i | (fault_clr ? 6'b0 : fault_q);
      ref_vld_o <= 1'b0;
      if (period_start) begin
        bypass_q <= byp_nxt;
        busy_q   <= 1'b1;
        bit_q    <= BW'(FRAC_W-1);
        s_q      <= '0;
        a_q      <= ref_a_i;
        b_q      <= ref_b_i;
        mag2_q   <= mag2_in;
        tgt_q    <= lsq_in << (2*FRAC_W);
        over_q   <= PW'(mag2_in) > lsq_in;
      end else if (busy_q) begin
        s_q <= s_nxt;
        if (bit_q == '0) begin
          busy_q    <= 1'b0;
          ref_vld_o <= 1'b1;
          clamp_o   <= over_q;
          ref_a_o   <= over_q ? sca : a_q;
          ref_b_o   <= over_q ? scb : b_q;
        end else begin
          bit_q <= bit_q - BW'(1);
        end
      end
    end
  end

  logic signed [2*REF_W-1:0] oa, ob, qa, qb;
  logic [MW-1:0]             omag, olim;
  assign oa   = (2*REF_W)'(ref_a_o);
  assign ob   = (2*REF_W)'(ref_b_o);
  assign qa   = oa * oa;
  assign qb   = ob * ob;
  assign omag = MW'($unsigned(qa)) + MW'($unsigned(qb));
  assign olim = MW'(lim_of(mi_o)) * MW'(lim_of(mi_o));

  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_clr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |=> $stable(bypass_o));
  assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mi_o == 3'd4) |-> (bypass_o == 6'b0));
  assert_mag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld_o |-> (omag <= olim));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld_o |=> !ref_vld_o);
endmodule

// File: tb/cell_bypass_ctrl_test.sv
module cell_bypass_ctrl_test;
  localparam int F  = 12;
  localparam int FS = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] fault_i = '0;
  logic fault_clr = 1'b0, period_start = 1'b0, row_fill_en = 1'b0;
  logic signed [15:0] ref_a_i = '0, ref_b_i = '0;
  logic [5:0] bypass_o, lvl_o;
  logic [2:0] mi_o;
  logic signed [15:0] ref_a_o, ref_b_o;
  logic ref_vld_o, clamp_o;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  cell_bypass_ctrl #(.REF_W(16), .FULL_SCALE(FS), .FRAC_W(F)) uut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .fault_clr(fault_clr),
    .period_start(period_start), .row_fill_en(row_fill_en),
    .ref_a_i(ref_a_i), .ref_b_i(ref_b_i), .bypass_o(bypass_o), .lvl_o(lvl_o),
    .mi_o(mi_o), .ref_a_o(ref_a_o), .ref_b_o(ref_b_o),
    .ref_vld_o(ref_vld_o), .clamp_o(clamp_o));

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic raise(input logic [5:0] m);
    @(negedge clk); fault_i = m;
    @(negedge clk); fault_i = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
  endtask

  task automatic strobe(input logic signed [15:0] a, input logic signed [15:0] b);
    @(negedge clk); ref_a_i = a; ref_b_i = b; period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
  endtask

  task automatic cfg(input string tag, input logic [5:0] eb, input logic [5:0] el, input logic [2:0] em);
    chk({tag, " R2 bypass"}, bypass_o, eb);
    chk({tag, " R3 level"}, lvl_o, el);
    chk({tag, " R4 index"}, mi_o, em);
  endtask

  task automatic result(input string tag, input int a, input int b, input int mi);
    longint lim, m2, s, ea, eb;
    bit cl;
    lim = longint'(FS) * mi / 4;
    m2 = longint'(a)*a + longint'(b)*b;
    cl = m2 > lim*lim;
    if (!cl) begin ea = a; eb = b; end
    else begin
      s = (1 << F) - 1;
      while (s > 0 && s*s*m2 > (lim*lim) << (2*F)) s--;
      ea = ((a < 0 ? -a : a) * s) >>> F;
      eb = ((b < 0 ? -b : b) * s) >>> F;
      if (a < 0) ea = -ea;
      if (b < 0) eb = -eb;
    end
    repeat (F-1) @(negedge clk);
    chk({tag, " R8 early"}, ref_vld_o, 0);
    @(negedge clk);
    chk({tag, " R8 valid"}, ref_vld_o, 1);
    chk({tag, cl ? " R7 clamp" : " R6 clamp"}, clamp_o, cl);
    chk({tag, cl ? " R7 a" : " R6 a"}, ref_a_o, ea);
    chk({tag, cl ? " R7 b" : " R6 b"}, ref_b_o, eb);
    @(negedge clk);
    chk({tag, " R8 pulse"}, ref_vld_o, 0);
  endtask

  task automatic t_reset();
    cfg("reset", 6'b0, 6'b101010, 3'd4);
    chk("reset R8 vld", ref_vld_o, 0);
    chk("reset R6 out", ref_a_o, 0);
  endtask

  task automatic t_healthy();
    strobe(16'sd3000, -16'sd4000);
    cfg("healthy", 6'b0, 6'b101010, 3'd4);
    result("healthy", 3000, -4000, 4);
  endtask

  task automatic t_single();
    raise(6'b000001);
    chk("single R2 before strobe", bypass_o, 0);
    strobe(16'sd16000, 16'sd0);
    cfg("single", 6'b000001, 6'b101001, 3'd3);
    result("single", 16000, 0, 3);
  endtask

  task automatic t_sticky();
    strobe(16'sd100, 16'sd100);
    cfg("sticky R1", 6'b000001, 6'b101001, 3'd3);
    result("sticky", 100, 100, 3);
    clear_all();
    strobe(16'sd100, 16'sd100);
    cfg("clear R1", 6'b0, 6'b101010, 3'd4);
    result("clear", 100, 100, 4);
  endtask

  task automatic t_same_phase();
    raise(6'b001100);
    strobe(-16'sd9000, 16'sd7000);
    cfg("samephase", 6'b001100, 6'b100010, 3'd2);
    result("samephase", -9000, 7000, 2);
    clear_all();
  endtask

  task automatic t_row_fill();
    row_fill_en = 1'b1;
    raise(6'b000101);
    strobe(16'sd5000, -16'sd5000);
    cfg("fill R5", 6'b010101, 6'b010101, 3'd2);
    result("fill", 5000, -5000, 2);
    row_fill_en = 1'b0;
    strobe(16'sd5000, -16'sd5000);
    cfg("nofill R5", 6'b000101, 6'b100101, 3'd2);
    result("nofill", 5000, -5000, 2);
    clear_all();
  endtask

  task automatic t_row_plus();
    row_fill_en = 1'b1;
    raise(6'b010111);
    strobe(-16'sd12000, -16'sd3000);
    cfg("rowplus", 6'b010111, 6'b010100, 3'd1);
    result("rowplus", -12000, -3000, 1);
    row_fill_en = 1'b0;
    clear_all();
  endtask

  task automatic t_all();
    raise(6'b111111);
    strobe(16'sd200, -16'sd300);
    cfg("all R9", 6'b111111, 6'b000000, 3'd0);
    result("all R9", 200, -300, 0);
    clear_all();
  endtask

  task automatic t_late_fault();
    strobe(16'sd0, 16'sd0);
    result("settle", 0, 0, 4);
    @(negedge clk); fault_i = 6'b100000; period_start = 1'b1; ref_a_i = 0; ref_b_i = 0;
    @(negedge clk); fault_i = '0; period_start = 1'b0;
    chk("late R2 not applied", bypass_o, 0);
    result("late", 0, 0, 4);
    strobe(16'sd0, 16'sd0);
    cfg("late next", 6'b100000, 6'b011010, 3'd3);
    result("late next", 0, 0, 3);
    clear_all();
  endtask

  task automatic t_diag();
    row_fill_en = 1'b1;
    raise(6'b001001);
    strobe(16'sd9000, 16'sd0);
    cfg("diag R5", 6'b001001, 6'b100101, 3'd2);
    result("diag", 9000, 0, 2);
    row_fill_en = 1'b0;
    clear_all();
  endtask

  task automatic t_restart();
    strobe(16'sd20000, 16'sd0);
    repeat (3) @(negedge clk);
    strobe(16'sd1000, 16'sd2000);
    result("restart", 1000, 2000, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_healthy();
    t_single();
    t_sticky();
    t_same_phase();
    t_row_fill();
    t_row_plus();
    t_all();
    t_late_fault();
    t_diag();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule